// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is a single timer channel that measures the time between qualifying transitions on an external input. A free-running up-counter advances on each pulse of a count-clock enable supplied from outside. When the input makes a transition of the selected kind, the block copies the running count into a capture register, restarts the counter from zero and raises a one-cycle interrupt. The capture register therefore holds the interval, in count-clock periods, between the two most recent qualifying transitions. At each capture a status flag records whether the counter rolled over during that interval.

Software controls the channel through a small word-wide register port. A control word has two one-shot trigger bits, one to start and one to stop, and status bits that report the running state and the rollover flag. A mode word selects which input transitions count and whether starting the channel raises an interrupt. A unit-enable input holds the whole channel in its default state while it is low. The input is asynchronous to the clock and passes through a synchronizer before edge detection.

Top module: `pulse_interval_timer`

## Requirements
- R1: Writing a word to address 0 with bit 0 set and bit 1 clear starts the channel: the running status (bit 2 of address 0 and the `run` port) reads 1 from the next cycle on. Bits 0 and 1 of address 0 always read 0.
- R2: After a start, the first cycle with `cnt_tick` high clears the counter (address 2) to 0. After that, each cycle with `cnt_tick` high adds one, wrapping from 0xFFFF to 0x0000 and continuing. Cycles with `cnt_tick` low leave the counter unchanged.
- R3: Bit 2 of the mode word (address 1) enables the start interrupt. If it is 1, `irq` is high for one cycle, in the cycle after the first counter clear that follows a start. If it is 0, starting produces no interrupt.
- R4: An input transition seen at clock edge k acts at clock edge k+2. In that action the counter value is copied to address 3, the counter becomes 0, and `irq` is high for the following cycle.
- R5: At each capture, bit 3 of address 0 (rollover flag) becomes 1 if the counter wrapped since the previous capture or the first clear after start. Otherwise it becomes 0.
- R6: Writing a word to address 0 with bit 1 set stops the channel. The running status clears, and the counter, capture value and rollover flag hold their values while the channel is stopped.
- R7: While the channel is running, a write to address 1 changes only bits 1:0. Bit 2 keeps its value. While the channel is stopped, all three bits are written.
- R8: While `unit_en` is 0, every register reads its default (all zero), `irq` and `run` are 0, and writes have no effect.
- R9: Mode bits 1:0 select the qualifying transition: 00 falling, 01 rising, 10 both, 11 none.
- R10: If a capture and a `cnt_tick` fall in the same cycle, the capture wins and the counter becomes 0.
- R11: Reads are combinational on `rd_addr`: 0 is control/status, 1 is mode, 2 is counter, 3 is capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Unit enable; low holds the channel in its default state |
| cnt_tick | input | 1 | Count-clock enable from an external prescaler |
| cap_pin | input | 1 | Asynchronous measured input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data |
| irq | output | 1 | One-cycle interrupt pulse |
| run | output | 1 | Channel running status |

## Verification
The assertions assume that control and mode writes come from a single master, one word per cycle, and that `cap_pin` is the only asynchronous input. `wr_en`, `wr_addr`, `wr_data` and `cnt_tick` are taken to be synchronous to `clk`. The stimulus drives every synchronous input just after a rising edge, so each input is stable for a full cycle. The measured input changes only at those same instants, so its path through the synchronizer has a fixed delay, and the model can predict the capture edge exactly. Stop and start are never set in the same write, except where the stop-wins case of R6 is intended.

// File: rtl/pit_pkg.sv
// Shared definitions for the pulse interval capture timer.
// Assumes a four-word register space; addresses are fixed by the read mux.
package pit_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      irq_at_start;
        edge_sel_e edge_sel;
    } mode_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;
    localparam logic [1:0] ADDR_CAP  = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int STAT_RUN_BIT   = 2;
    localparam int STAT_OVF_BIT   = 3;

endpackage

// File: rtl/pit_edge_detect.sv
// Synchronizes the asynchronous measured input and flags qualifying transitions.
// Assumes SYNC_STAGES >= 2; one extra flop keeps the previous synchronized level.
// The edge flag is combinational from flops and valid for one cycle per transition.
module pit_edge_detect
    import pit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      pin_i,
    input  edge_sel_e edge_sel_i,
    output logic      edge_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0] shreg;
    logic                 cur_lvl;
    logic                 prev_lvl;

    // Shift the input through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], pin_i};
        end
    end

    assign cur_lvl  = shreg[LAST];
    assign prev_lvl = shreg[SYNC_STAGES];

    // Decide whether the current transition matches the selected kind.
    always_comb begin
        unique case (edge_sel_i)
            EDGE_FALL: edge_o = prev_lvl && !cur_lvl;
            EDGE_RISE: edge_o = !prev_lvl && cur_lvl;
            EDGE_BOTH: edge_o = prev_lvl ^ cur_lvl;
            default:   edge_o = 1'b0;
        endcase
    end

    // R9: a rising selection never flags while the synchronized level falls
    a_r9_rise_only: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (edge_sel_i == EDGE_RISE && edge_o) |-> (shreg[LAST] && !shreg[SYNC_STAGES]));

endmodule

// File: rtl/pit_ctrl_regs.sv
// Holds the running status and the mode word, and decodes the one-shot triggers.
// Assumes one write per cycle; stop wins over start in the same word.
// Trigger bits are never stored, so they read as zero.
module pit_ctrl_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output mode_t             mode_o,
    output logic              start_o,
    output logic              stop_o
);

    logic  run_q;
    mode_t mode_q;
    logic  ctrl_wr;
    logic  mode_wr;

    assign ctrl_wr = wr_en && !clr && (wr_addr == ADDR_CTRL);
    assign mode_wr = wr_en && !clr && (wr_addr == ADDR_MODE);
    assign stop_o  = ctrl_wr && wr_data[CTRL_STOP_BIT];
    assign start_o = ctrl_wr && wr_data[CTRL_START_BIT] && !wr_data[CTRL_STOP_BIT];

    // Track the running status from the trigger strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= 1'b0;
        end else if (stop_o) begin
            run_q <= 1'b0;
        end else if (start_o) begin
            run_q <= 1'b1;
        end
    end

    // Update the mode word, locking all but the edge field while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q.edge_sel <= edge_sel_e'(wr_data[1:0]);
            if (!run_q) begin
                mode_q.irq_at_start <= wr_data[2];
            end
        end
    end

    assign run_o  = run_q;
    assign mode_o = mode_q;

    // R1: a start trigger leaves the channel running
    a_r1_start_runs: assert property (@(posedge clk) disable iff (!rst_n || clr)
        start_o |=> run_o);

    // R6: a stop trigger leaves the channel idle
    a_r6_stop_idles: assert property (@(posedge clk) disable iff (!rst_n || clr)
        stop_o |=> !run_o);

    // R7: the start-interrupt bit is frozen by writes while running
    a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (run_o && mode_wr) |=> $stable(mode_o.irq_at_start));

endmodule

// File: rtl/pit_count_capture.sv
// Runs the interval counter, captures it on qualifying edges and tracks rollover.
// Assumes start_i and edge_i are single-cycle and that run_i follows the triggers.
// The first count tick after a start clears the counter instead of incrementing it.
module pit_count_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             edge_i,
    input  logic             irq_mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             ovf_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             ovf_q;
    logic             wrap_q;
    logic             pend_q;
    logic             irq_q;
    logic             capture;

    assign capture = run_i && !pend_q && !start_i && edge_i;

    // Sequence start, counting, capture and rollover bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            cap_q  <= '0;
            ovf_q  <= 1'b0;
            wrap_q <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (start_i) begin
                pend_q <= 1'b1;
            end else if (run_i && pend_q) begin
                if (tick_i) begin
                    cnt_q  <= '0;
                    pend_q <= 1'b0;
                    wrap_q <= 1'b0;
                    irq_q  <= irq_mode_i;
                end
            end else if (run_i) begin
                if (capture) begin
                    cap_q  <= cnt_q;
                    cnt_q  <= '0;
                    ovf_q  <= wrap_q;
                    wrap_q <= 1'b0;
                    irq_q  <= 1'b1;
                end else if (tick_i) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_MAX) begin
                        wrap_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;
    assign ovf_o = ovf_q;
    assign irq_o = irq_q;

    // R4: a capture copies the count, restarts from zero and interrupts
    a_r4_capture_copies: assert property (@(posedge clk) disable iff (!rst_n || clr)
        capture |=> (cnt_o == '0 && cap_o == $past(cnt_o) && irq_o));

    // R10: a tick coinciding with a capture does not advance the counter
    a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (capture && tick_i) |=> (cnt_o == '0));

    // R2: an ordinary tick adds one, wrapping at the top
    a_r2_tick_counts: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (run_i && !pend_q && !start_i && !edge_i && tick_i)
            |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    // R5: a capture after a rollover reports it
    a_r5_ovf_reported: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (capture && wrap_q) |=> ovf_o);

    // R6: nothing moves while stopped
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (!run_i && !start_i) |=> ($stable(cnt_o) && $stable(ovf_o) && $stable(cap_o)));

endmodule

// File: rtl/pulse_interval_timer.sv
// Top of one input pulse interval capture channel.
// Assumes cnt_tick is synchronous to clk; cap_pin may be asynchronous.
// Reads are combinational; writes take effect at the next clock edge.
module pulse_interval_timer
    import pit_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             cnt_tick,
    input  logic             cap_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             run
);

    logic             clr;
    logic             run_s;
    mode_t            mode_s;
    logic             start_s;
    logic             stop_s;
    logic             edge_s;
    logic [CNT_W-1:0] cnt_s;
    logic [CNT_W-1:0] cap_s;
    logic             ovf_s;
    logic             irq_s;

    assign clr = !unit_en;

    pit_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .pin_i      (cap_pin),
        .edge_sel_i (mode_s.edge_sel),
        .edge_o     (edge_s)
    );

    pit_ctrl_regs #(.DATA_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_o   (run_s),
        .mode_o  (mode_s),
        .start_o (start_s),
        .stop_o  (stop_s)
    );

    pit_count_capture #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .run_i      (run_s),
        .start_i    (start_s),
        .tick_i     (cnt_tick),
        .edge_i     (edge_s),
        .irq_mode_i (mode_s.irq_at_start),
        .cnt_o      (cnt_s),
        .cap_o      (cap_s),
        .ovf_o      (ovf_s),
        .irq_o      (irq_s)
    );

    // Select the read word by address.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[STAT_RUN_BIT] = run_s;
                rd_data[STAT_OVF_BIT] = ovf_s;
            end
            ADDR_MODE: rd_data[2:0] = mode_s;
            ADDR_CNT:  rd_data      = cnt_s;
            default:   rd_data      = cap_s;
        endcase
    end

    assign irq = irq_s;
    assign run = run_s;

    // R8: a disabled unit is quiet and idle in the following cycle
    a_r8_unit_off: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (!irq && !run && cnt_s == '0 && cap_s == '0));

    // R6: the stop trigger is honoured by the outputs
    a_r6_stop_port: assert property (@(posedge clk) disable iff (!rst_n || clr)
        stop_s |=> !run);

endmodule

// File: tb/pulse_interval_timer_bench.sv
module pulse_interval_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         unit_en = 1'b1;
    logic         cnt_tick = 1'b1;
    logic         cap_pin = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq;
    logic         run;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_seen = 0;
    bit cmp_on = 0;
    bit done = 0;
    int tick_div = 1;
    int tick_phase = 0;

    // reference model state
    int m_s1, m_s2, m_s3;
    int m_run, m_pend, m_cnt, m_cap, m_ovf, m_wrap, m_irq, m_mode;

    pulse_interval_timer u_pulse_interval_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .unit_en  (unit_en),
        .cnt_tick (cnt_tick),
        .cap_pin  (cap_pin),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq),
        .run      (run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n || !unit_en) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_run = 0; m_pend = 0; m_cnt = 0; m_cap = 0;
            m_ovf = 0; m_wrap = 0; m_irq = 0; m_mode = 0;
        end else begin
            int sel;
            bit det, st, sp;
            sel = m_mode % 4;
            det = (sel == 0 && m_s3 == 1 && m_s2 == 0) ||
                  (sel == 1 && m_s3 == 0 && m_s2 == 1) ||
                  (sel == 2 && m_s3 != m_s2);
            sp = wr_en && wr_addr == 2'd0 && wr_data[1];
            st = wr_en && wr_addr == 2'd0 && wr_data[0] && !wr_data[1];
            m_irq = 0;
            if (st) begin
                m_pend = 1;
            end else if (m_run == 1 && m_pend == 1) begin
                if (cnt_tick) begin
                    m_cnt = 0; m_pend = 0; m_wrap = 0;
                    m_irq = (m_mode / 4) % 2;
                end
            end else if (m_run == 1) begin
                if (det) begin
                    m_cap = m_cnt; m_cnt = 0; m_ovf = m_wrap; m_wrap = 0; m_irq = 1;
                end else if (cnt_tick) begin
                    if (m_cnt == 65535) begin
                        m_cnt = 0; m_wrap = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            end
            if (wr_en && wr_addr == 2'd1) begin
                if (m_run == 1) m_mode = (m_mode & 4) | int'(wr_data[1:0]);
                else            m_mode = int'(wr_data[2:0]);
            end
            if (sp)      m_run = 0;
            else if (st) m_run = 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(cap_pin);
        end
    end

    // compare every cycle away from the active edge, then rotate the read address
    always @(negedge clk) begin
        if (irq) irq_seen++;
        if (cmp_on) begin
            int exp_rd;
            string tag;
            case (rd_addr)
                2'd0: begin exp_rd = m_ovf * 8 + m_run * 4; tag = "R5/R1 status"; end
                2'd1: begin exp_rd = m_mode; tag = "R7/R11 mode"; end
                2'd2: begin exp_rd = m_cnt; tag = "R2 counter"; end
                default: begin exp_rd = m_cap; tag = "R4 capture"; end
            endcase
            check(tag, int'(rd_data), exp_rd);
            check("R3 irq", int'(irq), m_irq);
            check("R1 run", int'(run), m_run);
        end
        rd_addr <= rd_addr + 2'd1;
    end

    // count-clock enable generator
    always @(posedge clk) begin
        #1;
        tick_phase++;
        cnt_tick = (tick_div <= 1) ? 1'b1 : ((tick_phase % tick_div) == 0);
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        forever begin
            @(negedge clk); #1;
            if (rd_addr == a) break;
        end
        v = int'(rd_data);
    endtask

    task automatic pin_toggle(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cap_pin = ~cap_pin;
            cycles(gap - 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v, irq0, cnt_a;
        cycles(3);
        rst_n = 1'b1;
        cmp_on = 1;
        // reset state, R11 read map defaults
        peek(2'd0, v); check("R11 reset status", v, 0);
        peek(2'd2, v); check("R11 reset counter", v, 0);

        // rising edges, start interrupt enabled
        reg_write(2'd1, 5);
        irq0 = irq_seen;
        reg_write(2'd0, 1);
        cycles(3);
        peek(2'd0, v); check("R1 running, triggers read 0", v, 4);
        check("R3 start irq with mode bit set", irq_seen - irq0, 1);
        // rising edge every 20 cycles: pin toggles every 10
        pin_toggle(8, 10);
        peek(2'd3, v); check("R4/R10 captured interval", v, 19);

        // R7: bit 2 locked while running, edge field follows
        reg_write(2'd1, 2);
        cycles(2);
        peek(2'd1, v); check("R7 mode lock", v, 6);
        // R9 both edges every 15 cycles
        pin_toggle(6, 15);
        peek(2'd3, v); check("R9 both-edge interval", v, 14);

        // R2 slower count clock
        tick_div = 3;
        pin_toggle(6, 30);
        tick_div = 1;

        // R5 rollover across a long gap
        cycles(70000);
        pin_toggle(1, 10);
        cycles(4);
        peek(2'd0, v); check("R5 rollover flagged", v, 12);
        pin_toggle(2, 10);
        cycles(4);
        peek(2'd0, v); check("R5 rollover cleared", v, 4);

        // R6 stop holds everything
        pin_toggle(1, 7);
        reg_write(2'd0, 2);
        cycles(2);
        peek(2'd2, cnt_a);
        pin_toggle(4, 9);
        peek(2'd2, v); check("R6 counter held", v, cnt_a);
        peek(2'd0, v); check("R6 stopped status", v, 0);

        // R3 start without interrupt, R9 falling edges
        reg_write(2'd1, 0);
        irq0 = irq_seen;
        reg_write(2'd0, 1);
        cycles(4);
        check("R3 no start irq", irq_seen - irq0, 0);
        pin_toggle(6, 12);
        peek(2'd3, v); check("R9 falling interval", v, 23);

        // R9 edge field 11 ignores transitions
        reg_write(2'd1, 3);
        cycles(3);
        irq0 = irq_seen;
        pin_toggle(6, 8);
        check("R9 no captures when none selected", irq_seen - irq0, 0);

        // R6 stop wins when both trigger bits are set
        reg_write(2'd0, 3);
        cycles(2);
        check("R6 stop wins", int'(run), 0);

        // R8 unit disabled: state cleared, writes ignored
        unit_en = 1'b0;
        reg_write(2'd1, 5);
        reg_write(2'd0, 1);
        cycles(2);
        check("R8 run held low", int'(run), 0);
        unit_en = 1'b1;
        peek(2'd1, v); check("R8 write ignored", v, 0);
        peek(2'd3, v); check("R8 capture cleared", v, 0);

        cycles(5);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule